// File: doc/BRIEF.md
# Filtered Over-Voltage Event Counter Latch

This block turns the raw output of an over-voltage comparator into a protective shutdown decision for a switching power controller. The comparator is looked at only during the off-time of the power switch, after a blanking interval that starts when the drive signal falls. A comparator assertion has to persist for a set number of system-clock cycles before it counts as a real event. Each switching cycle is armed by the falling drive edge and disarmed by the first validated event. If the next oscillator pulse arrives while the cycle is still armed, the consecutive-event count restarts from zero.

When the count reaches its limit of successive cycles with an event, the block asserts a latch-off output, which stops all drive pulses, and a supply-clamp enable, which holds the supply low. Both outputs stay high until power-on reset. Requiring several events on successive cycles rejects isolated noise spikes on the protection pin. The blanking and filter intervals are counted in system-clock cycles and set by parameters.

Top module: `ovp_event_latch`

## Requirements
- R1: While `por_n` is low, and after it is released with no further activity, `latch_off` and `clamp_en` are 0.
- R2: `cmp_raw` is ignored while `drv` is high and for BLANK_CYC clock edges beginning with the first edge at which `drv` is sampled low after being sampled high.
- R3: A comparator assertion counts as an event only after it has been sampled high and unblanked on FILT_CYC consecutive clock edges. A shorter run counts as nothing.
- R4: A switching cycle is armed only by a falling edge of `drv`. At most one event is counted per armed cycle, however often the comparator toggles. An event seen while no cycle is armed, such as before the first drive falling edge after reset, is not counted.
- R5: An `osc_pulse` sampled while the cycle is still armed resets the event count to zero. If an event and `osc_pulse` arrive on the same edge, the event is counted.
- R6: On the EVT_LIMIT-th event in successive cycles, `latch_off` and `clamp_en` both go high on the clock edge that counts that event. That edge is the one after the FILT_CYC-th qualified edge. With fewer events, both outputs stay low.
- R7: Once high, `latch_off` and `clamp_en` stay high regardless of `drv`, `osc_pulse` and `cmp_raw`. Only `por_n` low clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| drv | input | 1 | Power switch drive signal, high during on-time |
| osc_pulse | input | 1 | One-cycle pulse marking the start of each switching period |
| cmp_raw | input | 1 | Raw over-voltage comparator output |
| latch_off | output | 1 | High once the controller is latched off |
| clamp_en | output | 1 | Supply clamp enable, high together with latch_off |

## Verification
The assertions check several properties on every cycle:
- The latched state is sticky.
- A drive falling edge always opens the blanking window.
- A validated event is always preceded by a qualified comparator sample.
- At most one event is taken on consecutive edges.
- The latch rises only on an edge that counts an event.

Only the bench's scenarios can show the rest:
- the exact blanking and persistence lengths;
- the count being cleared by a missed cycle;
- a double pulse within one cycle counting once;
- an event ahead of any drive edge being dropped;
- the latch firing on exactly the fourth successive event.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  // Value loaded into the blanking counter at a drive falling edge.
  // The falling edge itself is blanked, so n edges need a reload of n-1.
  function automatic int unsigned blank_reload(input int unsigned n_edges);
    return (n_edges > 0) ? n_edges - 1 : 0;
  endfunction

  // Saturating increment used by the persistence filter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Event counter step, returns the next count (terminal count is lim-1).
  function automatic int unsigned evt_next(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? lim - 1 : v + 1;
  endfunction

endpackage

// File: rtl/ovp_blank.sv
module ovp_blank #(
  parameter int unsigned BLANK_CYC = 200
) (
  input  logic clk,
  input  logic por_n,
  input  logic drv,
  output logic drv_fall,
  output logic blank_act
);
  import ovp_pkg::*;

  localparam int unsigned BW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
  localparam logic [BW-1:0] RELOAD = BW'(blank_reload(BLANK_CYC));

  logic          drv_q;
  logic [BW-1:0] blank_cnt;

  assign drv_fall  = drv_q & ~drv;
  assign blank_act = drv_fall | (blank_cnt != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      drv_q     <= 1'b0;
      blank_cnt <= '0;
    end else begin
      drv_q <= drv;
      if (drv_fall)
        blank_cnt <= RELOAD;
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ovp_persist.sv
module ovp_persist #(
  parameter int unsigned FILT_CYC = 120
) (
  input  logic clk,
  input  logic por_n,
  input  logic qual_in,
  output logic valid_out
);
  import ovp_pkg::*;

  localparam int unsigned FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] LIM = FW'(FILT_CYC);

  logic [FW-1:0] run_cnt;

  assign valid_out = (run_cnt == LIM);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      run_cnt <= '0;
    else if (!qual_in)
      run_cnt <= '0;
    else
      run_cnt <= FW'(sat_inc(int'(run_cnt), FILT_CYC));
  end
endmodule

// File: rtl/ovp_event_count.sv
module ovp_event_count #(
  parameter int unsigned EVT_LIMIT = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic drv_fall,
  input  logic osc_pulse,
  input  logic evt_valid,
  output logic latched,
  output logic evt_take,
  output logic miss_clr
);
  import ovp_pkg::*;

  localparam int unsigned CW = (EVT_LIMIT < 2) ? 1 : $clog2(EVT_LIMIT);
  localparam logic [CW-1:0] TERM = CW'(EVT_LIMIT - 1);

  logic          armed;
  logic [CW-1:0] evt_cnt;

  assign evt_take = ~latched & armed & evt_valid;
  assign miss_clr = ~latched & armed & ~evt_valid & osc_pulse;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed   <= 1'b0;
      evt_cnt <= '0;
      latched <= 1'b0;
    end else if (!latched) begin
      if (evt_take) begin
        armed <= 1'b0;
        if (evt_cnt == TERM)
          latched <= 1'b1;
        else
          evt_cnt <= CW'(evt_next(int'(evt_cnt), EVT_LIMIT));
      end else begin
        if (miss_clr)
          evt_cnt <= '0;
        if (drv_fall)
          armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovp_event_latch.sv
module ovp_event_latch #(
  parameter int unsigned BLANK_CYC = 200,
  parameter int unsigned FILT_CYC  = 120,
  parameter int unsigned EVT_LIMIT = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic drv,
  input  logic osc_pulse,
  input  logic cmp_raw,
  output logic latch_off,
  output logic clamp_en
);
  logic drv_fall;
  logic blank_act;
  logic cmp_qual;
  logic evt_valid;
  logic evt_take;
  logic miss_clr;
  logic latched;

  ovp_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .por_n(por_n), .drv(drv),
    .drv_fall(drv_fall), .blank_act(blank_act)
  );

  assign cmp_qual = cmp_raw & ~drv & ~blank_act;

  ovp_persist #(.FILT_CYC(FILT_CYC)) u_persist (
    .clk(clk), .por_n(por_n), .qual_in(cmp_qual), .valid_out(evt_valid)
  );

  ovp_event_count #(.EVT_LIMIT(EVT_LIMIT)) u_count (
    .clk(clk), .por_n(por_n), .drv_fall(drv_fall), .osc_pulse(osc_pulse),
    .evt_valid(evt_valid), .latched(latched), .evt_take(evt_take),
    .miss_clr(miss_clr)
  );

  assign latch_off = latched;
  assign clamp_en  = latched;
endmodule

// File: rtl/ovp_event_latch_chk.sv
module ovp_event_latch_chk (
  input logic clk,
  input logic por_n,
  input logic drv_fall,
  input logic blank_act,
  input logic cmp_qual,
  input logic evt_valid,
  input logic evt_take,
  input logic miss_clr,
  input logic latch_off
);
  // R1
  always @(posedge clk) begin
    if (!por_n) a_r1_reset_low: assert (!latch_off);
  end

  a_r2_fall_opens_blank: assert property (@(posedge clk) disable iff (!por_n)
    drv_fall |=> blank_act);

  a_r3_valid_needs_qual: assert property (@(posedge clk) disable iff (!por_n)
    evt_valid |-> $past(cmp_qual));

  a_r4_one_take: assert property (@(posedge clk) disable iff (!por_n)
    evt_take |=> !evt_take);

  a_r5_miss_no_latch: assert property (@(posedge clk) disable iff (!por_n)
    miss_clr |=> !latch_off);

  a_r6_latch_on_take: assert property (@(posedge clk) disable iff (!por_n)
    $rose(latch_off) |-> $past(evt_take));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!por_n)
    latch_off |=> latch_off);
endmodule

bind ovp_event_latch ovp_event_latch_chk u_chk (
  .clk(clk), .por_n(por_n), .drv_fall(drv_fall), .blank_act(blank_act),
  .cmp_qual(cmp_qual), .evt_valid(evt_valid), .evt_take(evt_take),
  .miss_clr(miss_clr), .latch_off(latch_off)
);

// File: tb/ovp_event_latch_tb.sv
`timescale 1ns/1ps
module ovp_event_latch_tb;
  localparam int B = 8;
  localparam int F = 5;
  localparam int L = 4;
  localparam int ON_CYC = 6;
  localparam int OFF_CYC = 40;

  logic clk = 0, por_n = 0, drv = 0, osc_pulse = 0, cmp_raw = 0;
  logic latch_off, clamp_en;
  int n_tests = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_lat = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ovp_event_latch #(.BLANK_CYC(B), .FILT_CYC(F), .EVT_LIMIT(L)) u_dut (
    .clk(clk), .por_n(por_n), .drv(drv), .osc_pulse(osc_pulse),
    .cmp_raw(cmp_raw), .latch_off(latch_off), .clamp_en(clamp_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // A pulse is an event when its unblanked part lasts at least F edges.
  function automatic bit pulse_ok(input int s, input int len);
    int first;
    first = (s > B) ? s : B;
    return (len > 0) && ((s + len - first) >= F);
  endfunction

  function automatic bit in_win(input int t, input int s, input int len);
    return (t >= s) && (t < s + len);
  endfunction

  task automatic check_out(input string req);
    chk(latch_off == m_lat, req, latch_off, m_lat);
    chk(clamp_en == m_lat, req, clamp_en, m_lat);
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_n = 0; drv = 0; osc_pulse = 0; cmp_raw = 0;
    repeat (3) @(negedge clk);
    m_cnt = 0; m_lat = 0;
    check_out("R1 in reset");
    por_n = 1;
    repeat (2) @(negedge clk);
    check_out("R1 after release");
  endtask

  task automatic run_cycle(input int s1, input int l1, input int s2, input int l2,
                           input bit on_noise);
    bit ev;
    @(negedge clk);
    drv = 1; cmp_raw = on_noise;
    repeat (ON_CYC - 1) @(negedge clk);
    for (int t = 0; t < OFF_CYC; t++) begin
      @(negedge clk);
      drv = 0;
      cmp_raw = in_win(t, s1, l1) || in_win(t, s2, l2);
    end
    @(negedge clk);
    cmp_raw = 0; osc_pulse = 1;
    @(negedge clk);
    osc_pulse = 0;
    ev = pulse_ok(s1, l1) || pulse_ok(s2, l2);
    if (!m_lat) begin
      if (ev) begin
        m_cnt++;
        if (m_cnt == L) m_lat = 1;
      end else m_cnt = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    do_reset();

    // R6: three events do not latch, the fourth does
    for (int i = 0; i < 3; i++) run_cycle(B, F, 0, 0, 0);
    check_out("R6 three events no latch");
    run_cycle(B + 2, F + 3, 0, 0, 0);
    check_out("R6 fourth event latches");

    // R7: activity after latch has no effect, reset clears
    for (int i = 0; i < 3; i++) run_cycle(0, 0, 0, 0, 1);
    check_out("R7 sticky under activity");
    do_reset();

    // R5: a missed cycle clears the count
    for (int i = 0; i < 3; i++) run_cycle(B, F, 0, 0, 0);
    run_cycle(0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) run_cycle(B, F, 0, 0, 0);
    check_out("R5 miss clears count");
    run_cycle(B, F, 0, 0, 0);
    check_out("R5 latch after four fresh");
    do_reset();

    // R3: a run one edge short is no event
    for (int i = 0; i < 3; i++) run_cycle(B, F, 0, 0, 0);
    run_cycle(B + 1, F - 1, 0, 0, 0);
    run_cycle(B, F, 0, 0, 0);
    check_out("R3 short pulse rejected");
    do_reset();

    // R2: pulse mostly inside blanking, plus on-time noise
    for (int i = 0; i < 3; i++) run_cycle(B, F, 0, 0, 0);
    run_cycle(0, B + F - 1, 0, 0, 1);
    run_cycle(B, F, 0, 0, 0);
    check_out("R2 blanked pulse rejected");
    do_reset();

    // R4: two valid pulses in one cycle count once
    run_cycle(B, F + 1, B + F + 4, F + 1, 0);
    run_cycle(B, F, 0, 0, 0);
    run_cycle(B, F, 0, 0, 0);
    check_out("R4 double pulse counted once");
    run_cycle(B, F, 0, 0, 0);
    check_out("R4 latch on fourth cycle");
    do_reset();

    // R4: event before any drive falling edge is not counted
    @(negedge clk);
    cmp_raw = 1;
    repeat (F + 4) @(negedge clk);
    cmp_raw = 0;
    for (int i = 0; i < 3; i++) run_cycle(B, F, 0, 0, 0);
    check_out("R4 unarmed event ignored");
    run_cycle(B, F, 0, 0, 0);
    check_out("R4 latch after armed four");
    do_reset();

    // Random mix
    for (int i = 0; i < 150; i++) begin
      int s, len;
      bit nz;
      s = int'($urandom % 21);
      len = int'($urandom % 16);
      nz = 1'($urandom % 2);
      if ($urandom % 10 < 7) begin
        s = B + int'($urandom % 6);
        len = F + int'($urandom % 6);
      end
      run_cycle(s, len, 0, 0, nz);
      check_out("R6 random cycle");
      if (m_lat && ($urandom % 3 == 0)) do_reset();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule